// File: doc/BRIEF.md
# Conversion Synchronization Controller

This block lines up a converter's decimation filter and its modulator with an outside event. There are two trigger sources. The first is a dedicated sync pin, already synchronized to the system clock. The second is a sync command decoded by the serial interface, which reports it as a one-cycle pulse on the system clock that marks the command's final serial clock. The block drives two controls: a one-cycle clear for the filter counter, and a level that holds the modulator in reset until the sync completes.

The pin path holds the modulator for as long as the pin stays low. It releases on the first system-clock edge that samples the pin high. The command path arms first, then releases on the first serial-clock edge strobe that follows the command. Every release lasts one cycle. During that cycle a done pulse is raised and the modulator reset is still held. The modulator reset drops on the cycle after, unless a new trigger has started another hold. When a pin falling edge and a pending command meet, the pin wins.

Top module: `conv_sync_ctrl`

## Requirements
- R1: A falling edge on `sync_pin` is one whose level was high at the previous clock edge and is low at this one. On the clock edge that samples it, `filt_clr` goes high for exactly one cycle and `mod_rst` goes high.
- R2: After a pin-triggered hold, `mod_rst` stays high and `sync_done` stays low on every edge that samples `sync_pin` low.
- R3: During a pin hold, the first clock edge that samples `sync_pin` high raises `sync_done` for one cycle with `mod_rst` still high. Without a new trigger, `mod_rst` is low on the following cycle.
- R4: A `cmd_last` pulse sampled while idle raises `filt_clr` for one cycle and `mod_rst`. `mod_rst` then stays high on every cycle without an `sclk_edge`.
- R5: During a command hold, an edge that samples `sclk_edge` raises `sync_done` for one cycle with `mod_rst` high. Without a new trigger, `mod_rst` is low on the following cycle.
- R6: `sync_done` is never high on two cycles in a row.
- R7: A pin falling edge during a command hold takes priority, even when `sclk_edge` arrives on the same cycle. It clears the filter again and turns the hold into a pin hold. From then on `sclk_edge` does not release it.
- R8: While idle, `sclk_edge` has no effect. While in a pin hold, neither `sclk_edge` nor `cmd_last` changes any output.
- R9: While `rst_n` is low, and on the first cycle after it, all three outputs are low. This holds even when reset arrives during a hold.
- R10: A pin falling edge or a `cmd_last` pulse in the same cycle as `sync_done` starts a new hold: `filt_clr` pulses and `mod_rst` stays high.
- R11: A `cmd_last` pulse during a command hold restarts it. `filt_clr` pulses again and the hold continues, even when `sclk_edge` arrives on the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pin | input | 1 | Synchronized external sync level, active low |
| cmd_last | input | 1 | One-cycle pulse at the last serial clock of a sync command |
| sclk_edge | input | 1 | One-cycle strobe for each serial-clock edge |
| filt_clr | output | 1 | One-cycle filter counter clear |
| mod_rst | output | 1 | Modulator hold-in-reset level |
| sync_done | output | 1 | One-cycle pulse on the release cycle |

## Verification
The hardest case to reach is a collision of triggers on a single edge. One example is a pin falling edge that arrives together with the serial-clock strobe that would otherwise release an armed command. Another is a new trigger landing in the one-cycle release window. The stimulus table drives these deliberately. It arms a command, then drops the pin in the same vector as an `sclk_edge`. It also places pin falls and `cmd_last` pulses exactly on the cycle where `sync_done` is expected.

// File: rtl/conv_sync_pkg.sv
package conv_sync_pkg;

    typedef enum logic [1:0] {
        SY_IDLE     = 2'd0,
        SY_PIN_HOLD = 2'd1,
        SY_CMD_HOLD = 2'd2,
        SY_RELEASE  = 2'd3
    } sync_state_e;

    typedef struct packed {
        sync_state_e state;
        logic        clr;
    } sync_regs_t;

endpackage

// File: rtl/sync_pin_edge.sv
module sync_pin_edge #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic level_high
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= prev_d;
    end

    assign fall       = prev_q & ~pin;
    assign level_high = pin;

endmodule

// File: rtl/sync_seq_fsm.sv
module sync_seq_fsm
    import conv_sync_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_fall,
    input  logic        pin_high,
    input  logic        cmd_last,
    input  logic        sclk_edge,
    output sync_state_e state,
    output logic        clr
);

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.clr = 1'b0;
        unique case (r_q.state)
            SY_IDLE: begin
                if (pin_fall) begin
                    r_d.state = SY_PIN_HOLD;
                    r_d.clr   = 1'b1;
                end else if (cmd_last) begin
                    r_d.state = SY_CMD_HOLD;
                    r_d.clr   = 1'b1;
                end
            end
            SY_PIN_HOLD: begin
                if (pin_high) r_d.state = SY_RELEASE;
            end
            SY_CMD_HOLD: begin
                if (pin_fall) begin
                    r_d.state = SY_PIN_HOLD;
                    r_d.clr   = 1'b1;
                end else if (cmd_last) begin
                    r_d.state = SY_CMD_HOLD;
                    r_d.clr   = 1'b1;
                end else if (sclk_edge) begin
                    r_d.state = SY_RELEASE;
                end
            end
            SY_RELEASE: begin
                if (pin_fall) begin
                    r_d.state = SY_PIN_HOLD;
                    r_d.clr   = 1'b1;
                end else if (cmd_last) begin
                    r_d.state = SY_CMD_HOLD;
                    r_d.clr   = 1'b1;
                end else begin
                    r_d.state = SY_IDLE;
                end
            end
            default: r_d.state = SY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SY_IDLE;
            r_q.clr   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;
    assign clr   = r_q.clr;

    AST_PIN_STAYS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SY_PIN_HOLD && !pin_high) |=> (r_q.state == SY_PIN_HOLD)); // R2

    AST_CMD_SCLK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SY_CMD_HOLD && sclk_edge && !pin_fall && !cmd_last)
        |=> (r_q.state == SY_RELEASE)); // R5

    AST_PIN_BEATS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SY_CMD_HOLD && pin_fall) |=> (r_q.state == SY_PIN_HOLD && clr)); // R7

endmodule

// File: rtl/sync_out_map.sv
module sync_out_map
    import conv_sync_pkg::*;
(
    input  sync_state_e state,
    input  logic        clr_in,
    output logic        filt_clr,
    output logic        mod_rst,
    output logic        sync_done
);

    always_comb begin
        filt_clr  = clr_in;
        mod_rst   = (state != SY_IDLE);
        sync_done = (state == SY_RELEASE);
    end

endmodule

// File: rtl/conv_sync_ctrl.sv
module conv_sync_ctrl
    import conv_sync_pkg::*;
#(
    parameter logic PIN_IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pin,
    input  logic cmd_last,
    input  logic sclk_edge,
    output logic filt_clr,
    output logic mod_rst,
    output logic sync_done
);

    logic        pin_fall;
    logic        pin_high;
    sync_state_e st;
    logic        clr_q;

    sync_pin_edge #(.IDLE_LEVEL(PIN_IDLE_LEVEL)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (sync_pin),
        .fall       (pin_fall),
        .level_high (pin_high)
    );

    sync_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_fall  (pin_fall),
        .pin_high  (pin_high),
        .cmd_last  (cmd_last),
        .sclk_edge (sclk_edge),
        .state     (st),
        .clr       (clr_q)
    );

    sync_out_map u_out (
        .state     (st),
        .clr_in    (clr_q),
        .filt_clr  (filt_clr),
        .mod_rst   (mod_rst),
        .sync_done (sync_done)
    );

    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_pin) |=> (filt_clr && mod_rst)); // R1

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_clr && !$fell(sync_pin) && !cmd_last) |=> !filt_clr); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |=> !sync_done); // R6

    AST_DONE_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> mod_rst); // R3

endmodule

// File: tb/conv_sync_ctrl_test.sv
module conv_sync_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_pin = 1'b1;
    logic cmd_last = 1'b0;
    logic sclk_edge = 1'b0;
    logic filt_clr, mod_rst, sync_done;

    int checks = 0;
    int failures = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    conv_sync_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_pin  (sync_pin),
        .cmd_last  (cmd_last),
        .sclk_edge (sclk_edge),
        .filt_clr  (filt_clr),
        .mod_rst   (mod_rst),
        .sync_done (sync_done)
    );

    // {pin, cmd_last, sclk_edge, exp filt_clr, exp mod_rst, exp sync_done}
    localparam int NV = 21;
    localparam logic [5:0] VEC [NV] = '{
        6'b100_000, // idle
        6'b000_110, // R1 pin fall
        6'b001_010, // R8 sclk in pin hold
        6'b010_010, // R8 cmd in pin hold
        6'b100_011, // R3 release
        6'b100_000, // R3 back to idle
        6'b101_000, // R8 sclk in idle
        6'b110_110, // R4 arm
        6'b100_010, // R4 hold
        6'b111_110, // R11 restart with sclk same cycle
        6'b101_011, // R5 release
        6'b100_000, // R5 idle
        6'b110_110, // R4 arm again
        6'b001_110, // R7 pin fall beats sclk
        6'b001_010, // R7 sclk ignored
        6'b100_011, // R3 release
        6'b000_110, // R10 pin fall during done
        6'b100_011, // R3 release
        6'b110_110, // R10 cmd during done
        6'b101_011, // R5 release
        6'b100_000  // R6 idle
    };

    function automatic string tag_of(int i);
        case (i)
            1:             return "R1";
            2, 3, 6:       return "R8";
            4, 5, 15, 17:  return "R3";
            7, 8, 12:      return "R4";
            9:             return "R11";
            10, 11, 19:    return "R5";
            13, 14:        return "R7";
            16, 18:        return "R10";
            20:            return "R6";
            default:       return "R2";
        endcase
    endfunction

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {filt_clr, mod_rst, sync_done};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {filt_clr,mod_rst,sync_done} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(logic p, logic c, logic s);
        @(negedge clk);
        sync_pin  = p;
        cmd_last  = c;
        sclk_edge = s;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check("R9", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R9", 3'b000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            check(tag_of(i), VEC[i][2:0]);
        end

        // R2: long pin-low hold with stray strobes
        step(1'b0, 1'b0, 1'b0);
        check("R1", 3'b110);
        for (int k = 0; k < 30; k++) begin
            step(1'b0, k[0], k[1]);
            check("R2", 3'b010);
        end
        step(1'b1, 1'b0, 1'b0);
        check("R3", 3'b011);
        step(1'b1, 1'b0, 1'b0);
        check("R3", 3'b000);

        // R4: command hold without sclk persists
        step(1'b1, 1'b1, 1'b0);
        check("R4", 3'b110);
        for (int k = 0; k < 10; k++) begin
            step(1'b1, 1'b0, 1'b0);
            check("R4", 3'b010);
        end

        // R9: reset during a hold
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R9", 3'b000);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule